// File: doc/BRIEF.md
# Biphase-Mark Audio Line Transmitter

This block turns a three-wire serial stereo audio stream into a single biphase-mark coded line. It runs in the system clock domain. It oversamples the bit clock, the frame-sync and the data inputs, so the system clock must be several times faster than the bit clock. It reads one left/right sample pair per input frame. The serial format and the word width come from two select inputs.

Each complete pair is placed into two 32-slot subframes, left first and then right. A subframe carries a synchronising preamble, the audio word sent least significant bit first, and four trailing flag bits. The pair is sent during the next input frame. An input frame has 64 bit clocks and the coder needs 128 half-slots per frame, so the coder moves forward by one half-slot on every edge of the bit clock, rising and falling. The output rate therefore stays locked to the input rate with no buffering. Frames are counted in blocks of `FRAMES_PER_BLOCK`, and a fixed 32-bit channel-status pattern (`CS_BITS`) is spread over the first 32 frames of each block.

Top module: `biphase_audio_tx`

## Requirements
- R1: After reset `line_out` is low, and it stays low until the first bit-clock rising edge at which frame sync enters the left-channel level.
- R2: With `fmt_sel` = 0 (I2S), left is frame sync low. The word's MSB is sampled on the second bit-clock rising edge after frame sync changes.
- R3: With `fmt_sel` = 1 or 3 (left-justified), left is frame sync high. The MSB is sampled on the first rising edge after the change.
- R4: With `fmt_sel` = 2 (right-justified), left is frame sync high. The LSB is sampled on the 32nd rising edge of the half-frame.
- R5: `width_sel` 0/1/2/3 selects 16/18/20/24-bit words. The word fills the 24-bit audio field from its top. The unused low bits are zero, and data bits outside the word's window are ignored.
- R6: Subframe slots 4..27 carry the 24-bit audio field, LSB in slot 4. Slots 28 (validity) and 29 (user) are 0.
- R7: Slot 31 makes slots 4..31 contain an even number of ones.
- R8: Each bit slot is sent as two half-slots. Every half-slot follows one bit-clock edge. The line toggles at the start of every data slot, and toggles again mid-slot when the bit is 1.
- R9: Slots 0..3 carry a preamble as eight half-slot toggle flags (1 = toggle, first half-slot first). The left preamble of frame 0 of a block is 10011100, other left preambles are 10010011, and right preambles are 10010110. The frame counter wraps after `FRAMES_PER_BLOCK` frames.
- R10: Slot 30 of both subframes in frame k of a block is `CS_BITS[k]` for k < 32, and 0 otherwise.
- R11: The pair completed at a frame boundary is sent starting at that boundary's rising edge. Its left preamble's first toggle follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock |
| fsync_in | input | 1 | Frame sync / channel select |
| sdata_in | input | 1 | Serial audio data, sampled on bit-clock rising edges |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 left-justified |
| width_sel | input | 2 | 0:16, 1:18, 2:20, 3:24 bits |
| line_out | output | 1 | Biphase-mark coded line |

## Verification
The bench sends pseudo-random pairs in all three serial layouts and at each word width. It fills the bit positions outside the word window with ones, so a window placed one position wrong, or bits that are not zeroed, change the toggle pattern. One stream alternates all-ones and all-zeros words, which separates the parity rule from plain data coding. A stream longer than one block shows whether the block-start preamble and the channel-status bit follow the frame counter. Every half-slot toggle is compared against a model, which also checks the one-frame latency and that each line change lands on a bit-clock edge.

// File: rtl/biphase_audio_tx.sv
module biphase_audio_tx #(
  parameter int          FRAMES_PER_BLOCK = 192,
  parameter logic [31:0] CS_BITS          = 32'h0000_0004
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_in,
  input  logic       fsync_in,
  input  logic       sdata_in,
  input  logic [1:0] fmt_sel,
  input  logic [1:0] width_sel,
  output logic       line_out
);

  localparam int FIDX_W = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;
  localparam logic [7:0] PRE_BLK   = 8'b1001_1100;
  localparam logic [7:0] PRE_LEFT  = 8'b1001_0011;
  localparam logic [7:0] PRE_RIGHT = 8'b1001_0110;

  logic [2:0] bck_q;
  logic [1:0] fs_q, sd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bck_q <= '0;
      fs_q  <= '0;
      sd_q  <= '0;
    end else begin
      bck_q <= {bck_q[1:0], bclk_in};
      fs_q  <= {fs_q[0], fsync_in};
      sd_q  <= {sd_q[0], sdata_in};
    end

  logic rise, fall, step, fs_now, sd_now;
  assign rise   = bck_q[1] & ~bck_q[2];
  assign fall   = ~bck_q[1] & bck_q[2];
  assign step   = rise | fall;
  assign fs_now = fs_q[1];
  assign sd_now = sd_q[1];

  logic       left_lvl;
  logic [5:0] wbits, first;
  assign left_lvl = (fmt_sel != 2'd0);

  always_comb
    case (width_sel)
      2'd0:    wbits = 6'd16;
      2'd1:    wbits = 6'd18;
      2'd2:    wbits = 6'd20;
      default: wbits = 6'd24;
    endcase

  assign first = (fmt_sel == 2'd0) ? 6'd1 :
                 (fmt_sel == 2'd2) ? 6'd32 - wbits : 6'd0;

  logic        fs_prev;
  logic [5:0]  pos, pos_cur, k;
  logic [23:0] sh, sh_next, hold_l, buf_l, buf_r;
  logic        changed, in_win, frame_start;

  assign changed     = fs_now != fs_prev;
  assign pos_cur     = changed ? 6'd0 : ((&pos) ? pos : pos + 6'd1);
  assign k           = pos_cur - first;
  assign in_win      = (pos_cur >= first) && (k < wbits);
  assign frame_start = rise & changed & (fs_now == left_lvl);

  always_comb begin
    sh_next = changed ? '0 : sh;
    if (in_win) sh_next[5'd23 - k[4:0]] = sd_now;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fs_prev <= 1'b0;
      pos     <= '0;
      sh      <= '0;
      hold_l  <= '0;
      buf_l   <= '0;
      buf_r   <= '0;
    end else if (rise) begin
      fs_prev <= fs_now;
      pos     <= pos_cur;
      sh      <= sh_next;
      if (changed && fs_prev == left_lvl) hold_l <= sh;
      if (frame_start) begin
        buf_l <= hold_l;
        buf_r <= sh;
      end
    end

  logic [6:0]        slot, nslot;
  logic              active, started, line_q, ntog;
  logic [FIDX_W-1:0] frame_idx;

  assign nslot = slot + 7'd1;

  logic        ch, hf, cs, par, wbit;
  logic [4:0]  bn;
  logic [23:0] aud;
  logic [31:0] fidx_ext;
  logic [7:0]  pre;
  logic [2:0]  pidx;

  always_comb begin
    ch       = nslot[6];
    bn       = nslot[5:1];
    hf       = nslot[0];
    aud      = ch ? buf_r : buf_l;
    fidx_ext = 32'(frame_idx);
    cs       = (fidx_ext < 32) ? CS_BITS[fidx_ext[4:0]] : 1'b0;
    par      = ^{cs, aud};
    pre      = ch ? PRE_RIGHT : ((frame_idx == '0) ? PRE_BLK : PRE_LEFT);
    pidx     = {bn[1:0], hf};
    if (bn < 5'd28 && bn >= 5'd4) wbit = aud[bn - 5'd4];
    else if (bn == 5'd30)         wbit = cs;
    else if (bn == 5'd31)         wbit = par;
    else                          wbit = 1'b0;
    if (bn < 5'd4) ntog = pre[3'd7 - pidx];
    else           ntog = hf ? wbit : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot      <= '0;
      active    <= 1'b0;
      started   <= 1'b0;
      line_q    <= 1'b0;
      frame_idx <= '0;
    end else if (frame_start) begin
      slot      <= '0;
      active    <= 1'b1;
      started   <= 1'b1;
      line_q    <= ~line_q;
      frame_idx <= (!started || frame_idx == FIDX_W'(FRAMES_PER_BLOCK - 1)) ? '0 : frame_idx + 1'b1;
    end else if (step && active) begin
      if (slot == 7'd127) active <= 1'b0;
      else begin
        slot   <= nslot;
        line_q <= line_q ^ ntog;
      end
    end

  assign line_out = line_q;

endmodule

// File: rtl/biphase_audio_tx_chk.sv
module biphase_audio_tx_chk #(
  parameter int FRAMES = 192,
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          frame_start,
  input logic          active,
  input logic          started,
  input logic [6:0]    slot,
  input logic [FW-1:0] frame_idx,
  input logic          line_out
);

  logic       stepd, lvl;
  logic [5:0] ones;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stepd <= 1'b0;
      lvl   <= 1'b0;
      ones  <= '0;
    end else begin
      stepd <= step;
      if (stepd) begin
        lvl <= line_out;
        if (active) begin
          if (slot[5:1] == 5'd0) ones <= '0;
          else if (slot[0] && slot[5:1] >= 5'd4 && line_out != lvl) ones <= ones + 6'd1;
        end
      end
    end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !line_out);

  assert_change_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_out != $past(line_out)) |-> $past(step));

  assert_boundary_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stepd && active && !slot[0] && slot[5:1] >= 5'd4) |-> (line_out != lvl));

  assert_even_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stepd && active && slot[5:0] == 6'd63) |-> (((ones + 6'(line_out != lvl)) & 6'd1) == 6'd0));

  assert_frame_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(frame_idx) < FRAMES);

  assert_start_slot0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (slot == 7'd0 && active));

endmodule

bind biphase_audio_tx biphase_audio_tx_chk #(.FRAMES(FRAMES_PER_BLOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .frame_start(frame_start), .active(active),
  .started(started), .slot(slot), .frame_idx(frame_idx), .line_out(line_out));

// File: tb/biphase_audio_tx_test.sv
`timescale 1ns/1ps
module biphase_audio_tx_test;
  localparam int          BLOCK = 6;
  localparam logic [31:0] CSP   = 32'h0000_0035;

  logic clk = 0, rst_n = 0, bclk = 0, fs = 0, sd = 0;
  logic [1:0] fmt = 0, wsel = 0;
  logic line;
  int checks = 0, fails = 0, cur_w = 24;
  bit done = 0;
  logic rec [0:127];
  logic lvl;

  always #4 clk = ~clk;

  biphase_audio_tx #(.FRAMES_PER_BLOCK(BLOCK), .CS_BITS(CSP)) uut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fsync_in(fs), .sdata_in(sd),
    .fmt_sel(fmt), .width_sel(wsel), .line_out(line));

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  function automatic logic left_level(); return fmt != 2'd0; endfunction

  function automatic logic drive_bit(input logic [23:0] w, input int p);
    int first = (fmt == 2'd0) ? 1 : (fmt == 2'd2) ? 32 - cur_w : 0;
    if (p < first || p >= first + cur_w) return 1'b1;
    return w[cur_w - 1 - (p - first)];
  endfunction

  task automatic one_bit(input logic f, input logic d, input int q);
    fs = f; sd = d;
    wclk(2); bclk = 1; wclk(6); rec[2*q] = line;
    wclk(2); bclk = 0; wclk(6); rec[2*q+1] = line;
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
    for (int q = 0; q < 64; q++) begin
      logic lft = q < 32;
      one_bit(lft ? left_level() : ~left_level(), drive_bit(lft ? l : r, q % 32), q);
    end
  endtask

  function automatic logic [127:0] exp_frame(input logic [23:0] l, input logic [23:0] r, input int fidx);
    logic [127:0] t = '0;
    for (int sub = 0; sub < 2; sub++) begin
      logic [31:0] wd = '0;
      logic [7:0] pre = sub ? 8'b1001_0110 : (fidx == 0 ? 8'b1001_1100 : 8'b1001_0011);
      wd[27:4] = sub ? r : l;
      wd[30]   = (fidx < 32) ? CSP[fidx] : 1'b0;
      wd[31]   = ^wd[30:4];
      for (int b = 0; b < 32; b++)
        for (int h = 0; h < 2; h++)
          t[sub*64 + b*2 + h] = (b < 4) ? pre[7 - (b*2 + h)] : (h == 0 ? 1'b1 : wd[b]);
    end
    return t;
  endfunction

  task automatic check_frame(input logic [23:0] l, input logic [23:0] r, input int fidx, input string tag);
    logic [127:0] e = exp_frame(l, r, fidx);
    for (int sub = 0; sub < 2; sub++) begin
      int bad = -1; logic a = 0;
      for (int s = sub*64; s < sub*64 + 64; s++) begin
        logic t = rec[s] ^ (s == 0 ? lvl : rec[s-1]);
        if (t !== e[s] && bad < 0) begin bad = s; a = t; end
      end
      checks++;
      if (bad >= 0) begin
        fails++;
        $display("FAIL %s frame %0d sub %0d slot %0d: toggle actual %0b expected %0b", tag, fidx, sub, bad, a, e[bad]);
      end
    end
    lvl = rec[127];
  endtask

  function automatic logic [23:0] gen(input int k, input int seed);
    logic [31:0] v;
    if (seed == 0) v = (k % 2) ? 32'hFFFF_FFFF : 32'h0;
    else v = 32'h9E37_79B9 * (k + 1) + 32'(seed) * 32'h85EB_CA6B;
    return v[23:0] & ((24'h1 << cur_w) - 24'h1 | (cur_w == 24 ? 24'hFFFFFF : 24'h0));
  endfunction

  task automatic run_test(input logic [1:0] f, input logic [1:0] w, input int n, input int seed, input string tag);
    logic [23:0] pl = 0, pr = 0;
    int bad = 0;
    rst_n = 0; bclk = 0; fmt = f; wsel = w;
    cur_w = (w == 0) ? 16 : (w == 1) ? 18 : (w == 2) ? 20 : 24;
    wclk(4); rst_n = 1; wclk(2);
    for (int q = 0; q < 32; q++) begin
      one_bit(~left_level(), 1'b0, q);
      if (rec[2*q] !== 1'b0 || rec[2*q+1] !== 1'b0) bad++;
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL R1 %s: line active before first frame, %0d bad samples, expected 0", tag, bad);
    end
    lvl = 0;
    for (int k = 0; k <= n; k++) begin
      logic [23:0] l = (k < n) ? gen(2*k, seed) : 24'h0;
      logic [23:0] r = (k < n) ? gen(2*k + 1, seed) : 24'h0;
      send_frame(l, r);
      check_frame(pl, pr, k % BLOCK, tag);
      pl = l << (24 - cur_w);
      pr = r << (24 - cur_w);
    end
  endtask

  initial begin
    run_test(2'd0, 2'd3, 4, 11, "R2 R5 R6 R7 R8 R11 i2s/24");
    run_test(2'd1, 2'd0, 4, 23, "R3 R5 R8 lj/16");
    run_test(2'd2, 2'd1, 4, 37, "R4 R5 rj/18");
    run_test(2'd2, 2'd2, 3, 41, "R4 R5 rj/20");
    run_test(2'd3, 2'd2, 3, 53, "R3 fmt3/20");
    run_test(2'd0, 2'd0, 4, 0, "R7 R6 i2s/16 ones-zeros");
    run_test(2'd1, 2'd3, BLOCK + 2, 67, "R9 R10 lj/24 block wrap");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule